// File: doc/BRIEF.md
# Flash Row Self-Programming Controller

This block lets a processor rewrite its own word-organized flash one row at a time. Table writes from the processor fill a row-wide buffer of 24-bit instruction words. Each table write supplies either the low 16 bits or the high 8 bits of one word. The same writes capture the effective address. That address names the target row, and the buffer slot is the word index taken from the address. A small register bus holds a control register, two address registers and a write-only key register. Software can also set the address registers directly.

An erase or program command reaches the array only after an unlock. The key register must receive 0x55 and then 0xAA, with no other register write between them. A start write on the control register then spends that unlock. The command goes to an abstract array model as a one-cycle start pulse. The pulse carries the erase/program selection, the row number and the whole buffer. The block stays busy until the array returns a done pulse. While busy, it freezes everything the command depends on.

There are two state machines. The key machine has the states KEY_LOCKED, KEY_HALF and KEY_ARMED:
- A key write of 0x55 moves to KEY_HALF from any state.
- A key write of 0xAA moves KEY_HALF to KEY_ARMED.
- Any other key write moves to KEY_LOCKED.
- A start write moves to KEY_LOCKED.
- Any other register write moves KEY_HALF to KEY_LOCKED and leaves KEY_ARMED as it is.

The sequencer has the states SEQ_IDLE, SEQ_ISSUE and SEQ_WAIT:
- SEQ_IDLE moves to SEQ_ISSUE on an accepted start.
- SEQ_ISSUE always moves to SEQ_WAIT after one cycle.
- SEQ_WAIT moves to SEQ_IDLE on done.

Top module: `flashrow_ctrl`

## Requirements
- R1: After reset the block is in the following state:
  - busy reads 0.
  - Both address registers read 0.
  - No start pulse is issued.
  - Every buffer word is 0xFFFFFF.
- R2: Table writes load the buffer and are acknowledged as follows:
  - The buffer word index is address bits 5:1.
  - A table write with tw_high=0 stores tw_data into bits 15:0 of that word.
  - A table write with tw_high=1 stores tw_data[7:0] into bits 23:16 of that word.
  - tw_ack is high in the cycle after each tw_valid cycle.
- R3: A table write copies address bits 15:0 into the low address register (bus address 1). It copies bits 23:16 into the high address register (bus address 2), which reads zero-extended.
- R4: Software can write both address registers directly. When a direct address write and a table write happen in the same cycle, the table-write address wins.
- R5: The key register (bus address 3) always reads as zero.
- R6: Unlock and start behave as follows:
  - A start write is control register (address 0) bit 15 = 1.
  - A start write launches a command only when key writes of 0x55 and then 0xAA occurred with no other register write between them.
  - A repeated 0x55 keeps the sequence alive.
  - Any other register write after 0x55 breaks the sequence.
- R7: One start write consumes the unlock. A further start write needs a new unlock.
- R8: In the cycle after an accepted start write:
  - arr_start is high for exactly one cycle.
  - arr_erase equals bit 0 of the start write.
  - arr_row equals address bits 23:6.
  - arr_data holds buffer word i at bits 24i+23:24i.
  - Control register bit 15 (busy) reads 1 from that cycle until the cycle after arr_done.
- R9: While busy, the block ignores start writes, control writes, direct address writes and table writes. Table writes are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 key |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| tw_valid | input | 1 | Table write request |
| tw_high | input | 1 | 1 = high-byte write, 0 = low-word write |
| tw_addr | input | 24 | Effective address of the table write |
| tw_data | input | 16 | Table write data |
| tw_ack | output | 1 | Table write acknowledge, one cycle after tw_valid |
| arr_start | output | 1 | One-cycle command pulse to the array |
| arr_erase | output | 1 | 1 = row erase, 0 = row program |
| arr_row | output | 18 | Target row number (address bits 23:6) |
| arr_data | output | 768 | Row buffer, word i at bits 24i+23:24i |
| arr_done | input | 1 | Array completion pulse |

## Verification
Two events can land in the same cycle: a table write that captures its effective address, and a direct software write to the low address register. The bench drives both on one clock edge with different values, then reads both address registers over the bus. The captured table address must be there (R4), and the buffer word must show the table data. A second same-cycle collision is a table write during the busy window: the bench checks that the acknowledge still arrives while the exposed buffer stays unchanged.

// File: rtl/flashrow_pkg.sv
package flashrow_pkg;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_ARMED  = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] REG_CTRL    = 2'd0;
    localparam logic [1:0] REG_ADDR_LO = 2'd1;
    localparam logic [1:0] REG_ADDR_HI = 2'd2;
    localparam logic [1:0] REG_KEY     = 2'd3;

    localparam int CTL_GO_BIT    = 15;
    localparam int CTL_ERASE_BIT = 0;

endpackage

// File: rtl/flashrow_keylock.sv
module flashrow_keylock
    import flashrow_pkg::*;
#(
    parameter int          KEY_W      = 8,
    parameter logic [7:0]  KEY_FIRST  = 8'h55,
    parameter logic [7:0]  KEY_SECOND = 8'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    input  logic             go_wr,
    input  logic             other_wr,
    output logic             armed
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_LOCKED: begin
                if (key_wr)
                    state_d = (key_data == KEY_W'(KEY_FIRST)) ? KEY_HALF : KEY_LOCKED;
            end
            KEY_HALF: begin
                if (key_wr) begin
                    if (key_data == KEY_W'(KEY_FIRST))       state_d = KEY_HALF;
                    else if (key_data == KEY_W'(KEY_SECOND)) state_d = KEY_ARMED;
                    else                                     state_d = KEY_LOCKED;
                end else if (go_wr || other_wr) begin
                    state_d = KEY_LOCKED;
                end
            end
            KEY_ARMED: begin
                if (key_wr)
                    state_d = (key_data == KEY_W'(KEY_FIRST)) ? KEY_HALF : KEY_LOCKED;
                else if (go_wr)
                    state_d = KEY_LOCKED;
            end
            default: state_d = KEY_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            KEY_ARMED: armed = 1'b1;
            default:   armed = 1'b0;
        endcase
    end

    // R6
    armed_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_wr && key_data == KEY_W'(KEY_SECOND)));

    // R7
    go_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_wr |=> !armed);

endmodule

// File: rtl/flashrow_latches.sv
module flashrow_latches #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 24,
    parameter int LO_W   = 16,
    localparam int IDX_W = $clog2(WORDS),
    localparam int HI_W  = WORD_W - LO_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_high,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LO_W-1:0]         wr_data,
    output logic [WORDS*WORD_W-1:0] row_data
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (hit) begin
                if (wr_high) word_q[WORD_W-1:LO_W] <= wr_data[HI_W-1:0];
                else         word_q[LO_W-1:0]      <= wr_data;
            end
        end

        assign row_data[w*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/flashrow_seq.sv
module flashrow_seq
    import flashrow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic arr_done,
    output logic busy,
    output logic arr_start
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (launch)   state_d = SEQ_ISSUE;
            SEQ_ISSUE:               state_d = SEQ_WAIT;
            SEQ_WAIT:  if (arr_done) state_d = SEQ_IDLE;
            default:                 state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        arr_start = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  busy = 1'b0;
            SEQ_ISSUE: arr_start = 1'b1;
            SEQ_WAIT:  arr_start = 1'b0;
            default:   busy = 1'b0;
        endcase
    end

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R8
    busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> arr_start);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arr_done) |=> busy);

endmodule

// File: rtl/flashrow_ctrl.sv
module flashrow_ctrl
    import flashrow_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int WORD_W = 24,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int IDX_W     = $clog2(WORDS),
    localparam int ROW_LSB   = IDX_W + 1,
    localparam int ROW_W     = ADDR_W - ROW_LSB,
    localparam int HI_ADDR_W = ADDR_W - DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic                    tw_valid,
    input  logic                    tw_high,
    input  logic [ADDR_W-1:0]       tw_addr,
    input  logic [DATA_W-1:0]       tw_data,
    output logic                    tw_ack,
    output logic                    arr_start,
    output logic                    arr_erase,
    output logic [ROW_W-1:0]        arr_row,
    output logic [WORDS*WORD_W-1:0] arr_data,
    input  logic                    arr_done
);

    logic                 busy, armed;
    logic                 wr_ctrl, wr_lo, wr_hi, wr_key;
    logic                 go_wr, other_wr, launch, tw_apply;
    logic                 op_erase_q;
    logic [DATA_W-1:0]    addr_lo_q;
    logic [HI_ADDR_W-1:0] addr_hi_q;
    logic [ADDR_W-1:0]    full_addr;

    assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
    assign wr_lo    = reg_wr && (reg_addr == REG_ADDR_LO);
    assign wr_hi    = reg_wr && (reg_addr == REG_ADDR_HI);
    assign wr_key   = reg_wr && (reg_addr == REG_KEY);
    assign go_wr    = wr_ctrl && reg_wdata[CTL_GO_BIT];
    assign other_wr = reg_wr && !wr_key && !go_wr;
    assign launch   = go_wr && armed && !busy;
    assign tw_apply = tw_valid && !busy;

    flashrow_keylock #(.KEY_W(8)) i_keylock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_data (reg_wdata[7:0]),
        .go_wr    (go_wr),
        .other_wr (other_wr),
        .armed    (armed)
    );

    flashrow_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .arr_done  (arr_done),
        .busy      (busy),
        .arr_start (arr_start)
    );

    flashrow_latches #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .LO_W   (DATA_W)
    ) i_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_apply),
        .wr_high  (tw_high),
        .wr_idx   (tw_addr[IDX_W:1]),
        .wr_data  (tw_data),
        .row_data (arr_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q  <= '0;
            addr_hi_q  <= '0;
            op_erase_q <= 1'b0;
            tw_ack     <= 1'b0;
        end else begin
            tw_ack <= tw_valid;
            if (wr_ctrl && !busy)
                op_erase_q <= reg_wdata[CTL_ERASE_BIT];
            if (tw_apply) begin
                addr_lo_q <= tw_addr[DATA_W-1:0];
                addr_hi_q <= tw_addr[ADDR_W-1:DATA_W];
            end else if (!busy) begin
                if (wr_lo) addr_lo_q <= reg_wdata;
                if (wr_hi) addr_hi_q <= reg_wdata[HI_ADDR_W-1:0];
            end
        end
    end

    assign full_addr = {addr_hi_q, addr_lo_q};
    assign arr_row   = full_addr[ADDR_W-1:ROW_LSB];
    assign arr_erase = op_erase_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTL_GO_BIT]    = busy;
                reg_rdata[CTL_ERASE_BIT] = op_erase_q;
            end
            REG_ADDR_LO: reg_rdata = addr_lo_q;
            REG_ADDR_HI: reg_rdata = DATA_W'(addr_hi_q);
            REG_KEY:     reg_rdata = '0;
            default:     reg_rdata = '0;
        endcase
    end

    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_valid |=> tw_ack);

    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_valid && !busy) |=> (addr_lo_q == $past(tw_addr[DATA_W-1:0])));

    // R9
    busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arr_data));

    // R9
    busy_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arr_row));

endmodule

// File: tb/test_flashrow_ctrl.sv
module test_flashrow_ctrl;

    localparam int WORDS  = 32;
    localparam int WORD_W = 24;
    localparam int NVEC   = 8;

    // {effective address, high flag, data}
    localparam logic [40:0] VECS [NVEC] = '{
        {24'h0A1240, 1'b0, 16'h1111},
        {24'h0A1240, 1'b1, 16'h00AB},
        {24'h0A1242, 1'b0, 16'h2222},
        {24'h0A1242, 1'b1, 16'h00CD},
        {24'h0A1244, 1'b0, 16'h3333},
        {24'h0A127E, 1'b0, 16'h4444},
        {24'h0A127E, 1'b1, 16'h1299},
        {24'h0A1246, 1'b1, 16'h0077}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tw_valid = 1'b0;
    logic        tw_high = 1'b0;
    logic [23:0] tw_addr = '0;
    logic [15:0] tw_data = '0;
    logic        tw_ack;
    logic        arr_start;
    logic        arr_erase;
    logic [17:0] arr_row;
    logic [WORDS*WORD_W-1:0] arr_data;
    logic        arr_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    logic [WORD_W-1:0] exp_lat [WORDS];
    logic [23:0]       exp_addr;

    always #5 clk = ~clk;

    flashrow_ctrl i_flashrow_ctrl (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .tw_valid, .tw_high, .tw_addr, .tw_data, .tw_ack,
        .arr_start, .arr_erase, .arr_row, .arr_data, .arr_done
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tw_write(input logic [23:0] ea, input logic hi, input logic [15:0] d);
        tw_valid = 1'b1; tw_high = hi; tw_addr = ea; tw_data = d;
        @(negedge clk);
        tw_valid = 1'b0;
    endtask

    task automatic model_tw(input logic [23:0] ea, input logic hi, input logic [15:0] d);
        if (hi) exp_lat[ea[5:1]][23:16] = d[7:0];
        else    exp_lat[ea[5:1]][15:0]  = d;
        exp_addr = ea;
    endtask

    task automatic chk_data(input string req);
        for (int w = 0; w < WORDS; w++)
            chk(req, 32'(arr_data[w*WORD_W +: WORD_W]), 32'(exp_lat[w]));
    endtask

    task automatic finish_op();
        logic [15:0] rd;
        repeat (2) @(negedge clk);
        reg_read(2'd0, rd);
        chk("R8 busy during op", 32'(rd[15]), 32'd1);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        reg_read(2'd0, rd);
        chk("R8 busy after done", 32'(rd[15]), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [23:0] ea;
        logic        hi;
        logic [15:0] d;
        for (int w = 0; w < WORDS; w++) exp_lat[w] = 24'hFFFFFF;
        exp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, rd); chk("R1 busy", 32'(rd[15]), 32'd0);
        reg_read(2'd1, rd); chk("R1 addr lo", 32'(rd), 32'd0);
        reg_read(2'd2, rd); chk("R1 addr hi", 32'(rd), 32'd0);
        chk("R1 no start", 32'(arr_start), 32'd0);
        chk_data("R1 latches erased");

        // R2 R3 vector walk
        for (int v = 0; v < NVEC; v++) begin
            {ea, hi, d} = VECS[v];
            tw_write(ea, hi, d);
            model_tw(ea, hi, d);
            chk("R2 ack", 32'(tw_ack), 32'd1);
            reg_read(2'd1, rd); chk("R3 addr lo", 32'(rd), 32'(ea[15:0]));
            reg_read(2'd2, rd); chk("R3 addr hi", 32'(rd), 32'(ea[23:16]));
        end
        chk_data("R2 latch contents");

        // R6 start without unlock
        reg_write(2'd0, 16'h8000);
        chk("R6 no launch locked", 32'(arr_start), 32'd0);
        reg_read(2'd0, rd); chk("R6 idle locked", 32'(rd[15]), 32'd0);

        // R6 broken sequence
        reg_write(2'd3, 16'h0055);
        reg_write(2'd0, 16'h0000);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, 16'h8000);
        chk("R6 no launch broken", 32'(arr_start), 32'd0);

        // R6 repeated 0x55 then 0xAA unlocks, R8 program launch
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h00AA);
        reg_read(2'd3, rd); chk("R5 key reads zero", 32'(rd), 32'd0);
        reg_write(2'd0, 16'h8000);
        chk("R8 start pulse", 32'(arr_start), 32'd1);
        chk("R8 program op", 32'(arr_erase), 32'd0);
        chk("R8 row", 32'(arr_row), 32'(exp_addr >> 6));
        chk_data("R8 data at start");

        // R9 writes ignored while busy
        tw_write(24'h0A1240, 1'b0, 16'hDEAD);
        chk("R8 pulse single", 32'(arr_start), 32'd0);
        chk("R9 ack while busy", 32'(tw_ack), 32'd1);
        chk_data("R9 latches frozen");
        reg_write(2'd1, 16'h0000);
        reg_read(2'd1, rd); chk("R9 addr frozen", 32'(rd), 32'(exp_addr[15:0]));
        reg_write(2'd0, 16'h8001);
        chk("R9 start ignored", 32'(arr_start), 32'd0);
        reg_read(2'd0, rd); chk("R9 op frozen", 32'(rd[0]), 32'd0);
        finish_op();

        // R7 unlock consumed
        reg_write(2'd0, 16'h8000);
        chk("R7 second start refused", 32'(arr_start), 32'd0);

        // R4 direct address, erase
        reg_write(2'd1, 16'h5680);
        reg_write(2'd2, 16'h00F3);
        reg_read(2'd2, rd); chk("R4 direct hi", 32'(rd), 32'h00F3);
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, 16'h8001);
        chk("R8 erase pulse", 32'(arr_start), 32'd1);
        chk("R8 erase op", 32'(arr_erase), 32'd1);
        chk("R4 erase row", 32'(arr_row), 32'(24'hF35680 >> 6));
        finish_op();

        // R4 same-cycle direct write and table write
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h1111;
        tw_valid = 1'b1; tw_high = 1'b0; tw_addr = 24'h0B2200; tw_data = 16'hBEEF;
        @(negedge clk);
        reg_wr = 1'b0; tw_valid = 1'b0;
        model_tw(24'h0B2200, 1'b0, 16'hBEEF);
        reg_read(2'd1, rd); chk("R4 table wins lo", 32'(rd), 32'h2200);
        reg_read(2'd2, rd); chk("R4 table wins hi", 32'(rd), 32'h000B);
        chk("R4 collision data", 32'(arr_data[WORD_W-1:0]), 32'(exp_lat[0]));

        ended = 1'b1;
        summary();
        $finish;
    end

endmodule